// File: doc/BRIEF.md
# Miscellaneous Function Register Bridge

This block serves a 64-bit CPU-side register port and answers a small set of offsets. Most of them return fixed identity words: a version word with the value 0x11 plus a few parameterised constants. One offset holds the miscellaneous-function register. That register stores nothing itself. It gives a legacy-shaped view of two bits that live in the 32-bit configuration word of a neighbouring interrupt-controller feature block.

An input strap tells the bridge whether that neighbour has the extension that owns the configuration word. Without the extension, the misc register behaves as a fixed legacy register: reads show the controller as enabled, and writes are dropped.

With the extension, reads and writes of the misc register go through the neighbour's 32-bit configuration port. A read fetches the configuration word and maps two of its bits into the upper half of the 64-bit response. A write fetches the word, sets the requested bits and stores the result back, so bits can be set this way but never cleared. The CPU port holds its ready signal low until the configuration traffic has finished. Every access ends normally; there is no error response.

Top module: `misc_func_bridge`

## Requirements
- R1: After reset, with no request pending, `req_ready_o`, `cfg_rd_o` and `cfg_wr_o` are all low.
- R2: A read at offset 0x000 returns 64'h11 with `req_ready_o` high in the cycle the request is presented.
- R3: Reads at the other identity offsets (0x008, 0x010, 0x020) return their parameter words, and unmapped offsets read zero. Both complete in the presenting cycle. Writes to any of these offsets complete in the same cycle and produce no configuration traffic.
- R4: With the strap low, a read of the misc offset (0x420) returns a word with only bit 48 set. It completes in the presenting cycle and produces no configuration traffic.
- R5: With the strap low, a write to the misc offset completes in the presenting cycle and leaves the configuration word untouched: neither `cfg_rd_o` nor `cfg_wr_o` pulses.
- R6: With the strap high, a misc read pulses `cfg_rd_o` with ready low in the presenting cycle. The configuration data returns one cycle later, and the response completes in that cycle. In the response, bit 48 equals configuration bit 1, bit 49 equals configuration bit 2, and every other bit is zero.
- R7: With the strap high, a misc write pulses `cfg_rd_o` in the first cycle. In the next cycle it pulses `cfg_wr_o` together with ready. The write data is the fetched word, with bit 1 set if write-data bit 48 is 1 and bit 2 set if write-data bit 49 is 1.
- R8: A misc write never clears a configuration bit. With write-data bits 48 and 49 both zero, the fetched word is written back unchanged.
- R9: `cfg_rd_o` and `cfg_wr_o` are never high in the same cycle, and `cfg_wr_o` is only high in the cycle right after a `cfg_rd_o` pulse.
- R10: Misc write-data bits other than 48 and 49 have no effect on the configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_present_i | input | 1 | Strap: neighbour has the configuration extension |
| req_valid_i | input | 1 | CPU request present; held until ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (12) | Byte offset of the access |
| req_wdata_i | input | DATA_W (64) | Write data |
| req_ready_o | output | 1 | Access completes this cycle |
| rsp_rdata_o | output | DATA_W (64) | Read data, valid while ready is high on a read |
| cfg_rd_o | output | 1 | Configuration word fetch request |
| cfg_rdata_i | input | CFG_W (32) | Configuration word, valid the cycle after a fetch |
| cfg_wr_o | output | 1 | Configuration word store strobe |
| cfg_wdata_o | output | CFG_W (32) | Configuration word to store |

## Verification
The assertions rely on three things about the inputs. A request holds its valid, direction, offset and data steady until ready is seen. The strap changes only while no request is in flight. The neighbour drives `cfg_rdata_i` exactly one cycle after each fetch.

The bench models the neighbour's configuration register with that one-cycle latency. Each access goes through one task that keeps the request stable until ready is seen and then drops it. The bench changes the strap and presets the modelled register only between accesses, so every stimulus stays inside these assumptions.

// File: rtl/misc_bridge_pkg.sv
package misc_bridge_pkg;
   typedef enum logic {
      MB_IDLE  = 1'b0,
      MB_FETCH = 1'b1
   } mb_state_e;
endpackage

// File: rtl/misc_bridge_idmap.sv
module misc_bridge_idmap #(
   parameter int                       ADDR_W  = 12,
   parameter int                       DATA_W  = 64,
   parameter int                       N_ID    = 4,
   parameter logic [N_ID*ADDR_W-1:0]   ID_OFFS = '0,
   parameter logic [N_ID*DATA_W-1:0]   ID_VALS = '0
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [DATA_W-1:0] val_o
);
   logic [N_ID-1:0] hit_vec;

   for (genvar g = 0; g < N_ID; g++) begin : g_slot
      assign hit_vec[g] = (addr_i == ID_OFFS[g*ADDR_W +: ADDR_W]);
   end

   always_comb begin
      val_o = '0;
      for (int i = 0; i < N_ID; i++) begin
         if (hit_vec[i]) val_o = val_o | ID_VALS[i*DATA_W +: DATA_W];
      end
   end

   assign hit_o = |hit_vec;
endmodule

// File: rtl/misc_bridge_xlate.sv
module misc_bridge_xlate #(
   parameter int DATA_W      = 64,
   parameter int CFG_W       = 32,
   parameter int MISC_EN_BIT = 48,
   parameter int MISC_IE_BIT = 49,
   parameter int CFG_EN_BIT  = 1,
   parameter int CFG_IE_BIT  = 2
) (
   input  logic [CFG_W-1:0]  cfg_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] view_o,
   output logic [CFG_W-1:0]  merged_o
);
   always_comb begin
      view_o              = '0;
      view_o[MISC_EN_BIT] = cfg_i[CFG_EN_BIT];
      view_o[MISC_IE_BIT] = cfg_i[CFG_IE_BIT];
   end

   always_comb begin
      merged_o = cfg_i;
      if (wdata_i[MISC_EN_BIT]) merged_o[CFG_EN_BIT] = 1'b1;
      if (wdata_i[MISC_IE_BIT]) merged_o[CFG_IE_BIT] = 1'b1;
   end
endmodule

// File: rtl/misc_bridge_seq.sv
module misc_bridge_seq
   import misc_bridge_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic fetch_o,
   output logic cfg_rd_o
);
   mb_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         MB_IDLE:  if (start_i) state_d = MB_FETCH;
         MB_FETCH: state_d = MB_IDLE;
         default:  state_d = MB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= MB_IDLE;
      else        state_q <= state_d;
   end

   assign cfg_rd_o = (state_q == MB_IDLE) && start_i;
   assign fetch_o  = (state_q == MB_FETCH);
endmodule

// File: rtl/misc_func_bridge.sv
module misc_func_bridge #(
   parameter int                     ADDR_W      = 12,
   parameter int                     DATA_W      = 64,
   parameter int                     CFG_W       = 32,
   parameter logic [ADDR_W-1:0]      MISC_OFF    = 12'h420,
   parameter int                     MISC_EN_BIT = 48,
   parameter int                     MISC_IE_BIT = 49,
   parameter int                     CFG_EN_BIT  = 1,
   parameter int                     CFG_IE_BIT  = 2,
   parameter int                     N_ID        = 4,
   parameter logic [N_ID*ADDR_W-1:0] ID_OFFS     = {12'h020, 12'h010, 12'h008, 12'h000},
   parameter logic [N_ID*DATA_W-1:0] ID_VALS     = {64'h0000_0000_0000_5A5A,
                                                    64'h0123_4567_89AB_CDEF,
                                                    64'h0000_0000_0000_000E,
                                                    64'h0000_0000_0000_0011}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_present_i,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              req_ready_o,
   output logic [DATA_W-1:0] rsp_rdata_o,
   output logic              cfg_rd_o,
   input  logic [CFG_W-1:0]  cfg_rdata_i,
   output logic              cfg_wr_o,
   output logic [CFG_W-1:0]  cfg_wdata_o
);
   if (MISC_EN_BIT >= DATA_W || MISC_IE_BIT >= DATA_W) begin : g_bad_misc
      $error("misc bit position outside the data width");
   end
   if (CFG_EN_BIT >= CFG_W || CFG_IE_BIT >= CFG_W) begin : g_bad_cfg
      $error("config bit position outside the config width");
   end
   if (MISC_EN_BIT == MISC_IE_BIT || CFG_EN_BIT == CFG_IE_BIT) begin : g_bad_alias
      $error("enable and encode bits must differ");
   end

   logic              is_misc, use_cfg, fetch, id_hit;
   logic [DATA_W-1:0] id_val, cfg_view, legacy_view;

   assign is_misc = (req_addr_i == MISC_OFF);
   assign use_cfg = req_valid_i && is_misc && ext_present_i;

   misc_bridge_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (use_cfg),
      .fetch_o  (fetch),
      .cfg_rd_o (cfg_rd_o)
   );

   misc_bridge_idmap #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .N_ID (N_ID),
      .ID_OFFS (ID_OFFS), .ID_VALS (ID_VALS)
   ) u_idmap (
      .addr_i (req_addr_i),
      .hit_o  (id_hit),
      .val_o  (id_val)
   );

   misc_bridge_xlate #(
      .DATA_W (DATA_W), .CFG_W (CFG_W),
      .MISC_EN_BIT (MISC_EN_BIT), .MISC_IE_BIT (MISC_IE_BIT),
      .CFG_EN_BIT (CFG_EN_BIT), .CFG_IE_BIT (CFG_IE_BIT)
   ) u_xlate (
      .cfg_i    (cfg_rdata_i),
      .wdata_i  (req_wdata_i),
      .view_o   (cfg_view),
      .merged_o (cfg_wdata_o)
   );

   always_comb begin
      legacy_view              = '0;
      legacy_view[MISC_EN_BIT] = 1'b1;
   end

   assign req_ready_o = req_valid_i && (use_cfg ? fetch : 1'b1);
   assign cfg_wr_o    = fetch && req_write_i;

   always_comb begin
      rsp_rdata_o = '0;
      if (req_valid_i && !req_write_i) begin
         if (is_misc)     rsp_rdata_o = ext_present_i ? cfg_view : legacy_view;
         else if (id_hit) rsp_rdata_o = id_val;
      end
   end
endmodule

// File: rtl/misc_bridge_chk.sv
module misc_bridge_chk #(
   parameter int                ADDR_W      = 12,
   parameter int                DATA_W      = 64,
   parameter int                CFG_W       = 32,
   parameter logic [ADDR_W-1:0] MISC_OFF    = 12'h420,
   parameter int                MISC_EN_BIT = 48,
   parameter int                MISC_IE_BIT = 49,
   parameter int                CFG_EN_BIT  = 1,
   parameter int                CFG_IE_BIT  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ext_present_i,
   input logic              req_valid_i,
   input logic              req_write_i,
   input logic [ADDR_W-1:0] req_addr_i,
   input logic              req_ready_o,
   input logic [DATA_W-1:0] rsp_rdata_o,
   input logic              cfg_rd_o,
   input logic [CFG_W-1:0]  cfg_rdata_i,
   input logic              cfg_wr_o,
   input logic [CFG_W-1:0]  cfg_wdata_o
);
   localparam logic [DATA_W-1:0] LEGACY = DATA_W'(1) << MISC_EN_BIT;

   // R9
   rd_wr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_rd_o && cfg_wr_o));
   // R7
   wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_o |-> $past(cfg_rd_o));
   // R8
   no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_o |-> ((cfg_wdata_o & cfg_rdata_i) == cfg_rdata_i));
   // R6
   fetch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_o |-> !req_ready_o);
   // R6
   fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_o |=> req_ready_o);
   // R6
   view_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready_o && !req_write_i && ext_present_i && req_addr_i == MISC_OFF)
      |-> (rsp_rdata_o[MISC_EN_BIT] == cfg_rdata_i[CFG_EN_BIT] &&
           rsp_rdata_o[MISC_IE_BIT] == cfg_rdata_i[CFG_IE_BIT] &&
           $countones(rsp_rdata_o) <= 2));
   // R4
   legacy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_present_i && req_valid_i && !req_write_i && req_addr_i == MISC_OFF)
      |-> (req_ready_o && rsp_rdata_o == LEGACY));
   // R5
   absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_present_i |-> (!cfg_rd_o && !cfg_wr_o));
endmodule

bind misc_func_bridge misc_bridge_chk #(
   .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CFG_W (CFG_W), .MISC_OFF (MISC_OFF),
   .MISC_EN_BIT (MISC_EN_BIT), .MISC_IE_BIT (MISC_IE_BIT),
   .CFG_EN_BIT (CFG_EN_BIT), .CFG_IE_BIT (CFG_IE_BIT)
) u_chk (
   .clk (clk), .rst_n (rst_n), .ext_present_i (ext_present_i),
   .req_valid_i (req_valid_i), .req_write_i (req_write_i), .req_addr_i (req_addr_i),
   .req_ready_o (req_ready_o), .rsp_rdata_o (rsp_rdata_o),
   .cfg_rd_o (cfg_rd_o), .cfg_rdata_i (cfg_rdata_i),
   .cfg_wr_o (cfg_wr_o), .cfg_wdata_o (cfg_wdata_o)
);

// File: tb/misc_func_bridge_bench.sv
module misc_func_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic        req_ready;
   logic [63:0] rsp_rdata;
   logic        cfg_rd, cfg_wr;
   logic [31:0] cfg_rdata = '0;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_reg = '0;
   int          rd_cnt = 0, wr_cnt = 0;
   int          checks = 0, errors = 0;

   always #5 clk = ~clk;

   misc_func_bridge u_misc_func_bridge (
      .clk (clk), .rst_n (rst_n), .ext_present_i (ext),
      .req_valid_i (req_valid), .req_write_i (req_write),
      .req_addr_i (req_addr), .req_wdata_i (req_wdata),
      .req_ready_o (req_ready), .rsp_rdata_o (rsp_rdata),
      .cfg_rd_o (cfg_rd), .cfg_rdata_i (cfg_rdata),
      .cfg_wr_o (cfg_wr), .cfg_wdata_o (cfg_wdata)
   );

   // neighbour config register model, one-cycle read latency
   always @(posedge clk) begin
      if (cfg_rd) begin cfg_rdata <= cfg_reg; rd_cnt <= rd_cnt + 1; end
      if (cfg_wr) begin cfg_reg <= cfg_wdata; wr_cnt <= wr_cnt + 1; end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input bit wr, input logic [11:0] a, input logic [63:0] wd,
                         output logic [63:0] rd, output int cyc);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; cyc = 1;
      #1;
      while (!req_ready && cyc < 20) begin
         @(negedge clk); #1; cyc++;
      end
      rd = rsp_rdata;
      @(posedge clk); #1;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 ready", 64'(req_ready), 64'd0);
      check("R1 cfg_rd", 64'(cfg_rd), 64'd0);
      check("R1 cfg_wr", 64'(cfg_wr), 64'd0);
   endtask

   task automatic t_identity;
      logic [63:0] rd; int cyc; int r0, w0;
      access(0, 12'h000, '0, rd, cyc);
      check("R2 version", rd, 64'h11);
      check("R2 latency", 64'(cyc), 64'd1);
      access(0, 12'h008, '0, rd, cyc);
      check("R3 id 0x008", rd, 64'h0000_0000_0000_000E);
      access(0, 12'h010, '0, rd, cyc);
      check("R3 id 0x010", rd, 64'h0123_4567_89AB_CDEF);
      access(0, 12'h020, '0, rd, cyc);
      check("R3 id 0x020", rd, 64'h0000_0000_0000_5A5A);
      access(0, 12'h100, '0, rd, cyc);
      check("R3 unmapped", rd, 64'd0);
      r0 = rd_cnt; w0 = wr_cnt;
      access(1, 12'h000, '1, rd, cyc);
      check("R3 write latency", 64'(cyc), 64'd1);
      check("R3 write traffic", 64'(rd_cnt - r0 + wr_cnt - w0), 64'd0);
      access(0, 12'h000, '0, rd, cyc);
      check("R3 version after write", rd, 64'h11);
   endtask

   task automatic t_absent;
      logic [63:0] rd; int cyc; int r0, w0;
      ext = 1'b0; cfg_reg = 32'h0000_1000;
      r0 = rd_cnt; w0 = wr_cnt;
      access(0, 12'h420, '0, rd, cyc);
      check("R4 legacy view", rd, 64'h0001_0000_0000_0000);
      check("R4 latency", 64'(cyc), 64'd1);
      access(1, 12'h420, 64'h0003_0000_0000_0000, rd, cyc);
      check("R5 latency", 64'(cyc), 64'd1);
      check("R5 traffic", 64'(rd_cnt - r0 + wr_cnt - w0), 64'd0);
      check("R5 config kept", 64'(cfg_reg), 64'h1000);
      access(0, 12'h420, '0, rd, cyc);
      check("R5 view after write", rd, 64'h0001_0000_0000_0000);
   endtask

   task automatic t_present;
      logic [63:0] rd; int cyc; int r0, w0;
      ext = 1'b1; cfg_reg = 32'h0;
      r0 = rd_cnt; w0 = wr_cnt;
      access(0, 12'h420, '0, rd, cyc);
      check("R6 view zero", rd, 64'd0);
      check("R6 latency", 64'(cyc), 64'd2);
      check("R6 one fetch", 64'(rd_cnt - r0), 64'd1);
      check("R6 no store", 64'(wr_cnt - w0), 64'd0);
      r0 = rd_cnt; w0 = wr_cnt;
      access(1, 12'h420, 64'h0001_0000_0000_0000, rd, cyc);
      @(negedge clk);
      check("R7 set enable", 64'(cfg_reg), 64'h2);
      check("R7 latency", 64'(cyc), 64'd2);
      check("R7 one fetch one store", 64'((rd_cnt - r0) * 4 + (wr_cnt - w0)), 64'd5);
      access(0, 12'h420, '0, rd, cyc);
      check("R6 enable view", rd, 64'h0001_0000_0000_0000);
      access(1, 12'h420, 64'h0002_0000_0000_0000, rd, cyc);
      @(negedge clk);
      check("R7 set encode", 64'(cfg_reg), 64'h6);
      access(0, 12'h420, '0, rd, cyc);
      check("R6 both view", rd, 64'h0003_0000_0000_0000);
   endtask

   task automatic t_no_clear;
      logic [63:0] rd; int cyc;
      ext = 1'b1; cfg_reg = 32'hA5A5_0F09;
      access(0, 12'h420, '0, rd, cyc);
      check("R6 other bits hidden", rd, 64'd0);
      access(1, 12'h420, 64'd0, rd, cyc);
      @(negedge clk);
      check("R8 unchanged", 64'(cfg_reg), 64'hA5A5_0F09);
      access(1, 12'h420, ~64'h0003_0000_0000_0000, rd, cyc);
      @(negedge clk);
      check("R10 other bits ignored", 64'(cfg_reg), 64'hA5A5_0F09);
      access(1, 12'h420, 64'h0001_0000_0000_0000, rd, cyc);
      @(negedge clk);
      check("R7 merge keeps bits", 64'(cfg_reg), 64'hA5A5_0F0B);
      cfg_reg = 32'h0000_0006;
      access(1, 12'h420, 64'd0, rd, cyc);
      @(negedge clk);
      check("R8 set bits stay", 64'(cfg_reg), 64'h6);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_identity();
      t_absent();
      t_present();
      t_no_clear();
      repeat (2) @(posedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule